// File: doc/BRIEF.md
# Fiducial-Advanced Timestamp Pipeline

This block holds a short pipeline of timestamp entries, one for the pulse being served now and one for each of the next few pulses. Each entry has a seconds word, a nanoseconds word whose low 17 bits encode a pulse ID, and a status word. A fiducial strobe moves every entry one slot closer to the current position. The same strobe fills the farthest slot with the newest entry received since the previous strobe. If no entry has arrived, the slot gets a placeholder marked invalid.

On every strobe the block inspects the pulse ID entering the pipeline. It counts IDs that carry the invalid code and IDs that do not follow the previous far-future ID. It raises an error flag for the strobe that found either problem. It also invalidates the incoming entry when the three upcoming pulses would all carry the same ID. Downstream logic reads the current slot for its timestamp, and reads the counters for diagnostics.

Top module: `fid_ts_pipeline`

## Requirements
- R1: While rst_n is low, every slot takes seconds from sys_sec_i, nanoseconds from sys_nsec_i, and status 0xFFFFFFFF (invalid); both counters clear and err_o goes low.
- R2: On a clock edge with fid_i high, slot i takes the old contents of slot i+1 for every i below DEPTH-1. On an edge with fid_i low, no slot changes.
- R3: On a strobe, slot DEPTH-1 takes the entry offered on new_*_i in that cycle if new_valid_i is high. Otherwise it takes the last entry offered since the previous strobe. Status 0 means valid.
- R4: If no entry was offered since the previous strobe, slot DEPTH-1 takes seconds sys_sec_i, nanoseconds sys_nsec_i with bits 16:0 forced to 0x1FFFF, and status 0xFFFFFFFF.
- R5: The pulse ID is bits 16:0 of the nanoseconds word, and 0x1FFFF marks it invalid. On each strobe that loads an invalid ID, bad_id_cnt_o increments by one.
- R6: On a strobe where both the loaded ID and the ID previously in slot DEPTH-1 are valid, gap_cnt_o increments by one if the loaded ID is not the successor. The successor is taken modulo 0x1FFFF, so 0x1FFFE is followed by 0.
- R7: If the loaded ID equals the IDs in both slot DEPTH-1 and slot DEPTH-2 before the strobe, the loaded entry's status becomes 0xFFFFFFFF regardless of its input status.
- R8: After each strobe, err_o is high exactly when that strobe counted an invalid ID or a gap. Between strobes it holds its value.
- R9: Each counter is CNT_W bits wide and stays at 2^CNT_W-1 once it reaches it.
- R10: cnt_clr_i high at an edge clears both counters, and this takes priority over an increment at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fid_i | input | 1 | Fiducial strobe, one cycle per pulse |
| new_valid_i | input | 1 | A new far-future entry is offered this cycle |
| new_sec_i | input | 32 | Seconds word of the offered entry |
| new_nsec_i | input | 32 | Nanoseconds word of the offered entry (pulse ID in bits 16:0) |
| new_stat_i | input | 32 | Status word of the offered entry |
| sys_sec_i | input | 32 | System time, seconds |
| sys_nsec_i | input | 32 | System time, nanoseconds |
| cnt_clr_i | input | 1 | Clear both error counters |
| slot_sec_o | output | DEPTH x 32 | Seconds word of each slot; index 0 is the current pulse |
| slot_nsec_o | output | DEPTH x 32 | Nanoseconds word of each slot |
| slot_stat_o | output | DEPTH x 32 | Status word of each slot |
| err_o | output | 1 | Last strobe found an invalid or non-consecutive pulse ID |
| bad_id_cnt_o | output | CNT_W | Count of invalid pulse IDs loaded |
| gap_cnt_o | output | CNT_W | Count of non-consecutive pulse IDs loaded |

## Verification
The bench targets these corner cases:
- The step from 0x1FFFE to 0. A design that compares modulo 2^17 would count a false gap there.
- A strobe with no entry offered. A design that leaves the far slot unchanged would duplicate the previous entry instead of inserting an invalid placeholder.
- An entry offered in the same cycle as the strobe, and two entries offered between strobes. Here the wrong entry could be kept, or a held entry could leak into the next pulse.
- Three identical upcoming IDs. A repeat check aimed at the wrong slots would leave the entry valid or invalidate the wrong one.
- Counters driven past their maximum while a clear arrives. A design there could wrap to zero or let the increment win over the clear.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int unsigned TS_W  = 32;
  localparam int unsigned PID_W = 17;
  localparam logic [PID_W-1:0] PID_BAD  = {PID_W{1'b1}};
  localparam logic [PID_W-1:0] PID_LAST = {{(PID_W-1){1'b1}}, 1'b0};

  typedef struct packed {
    logic [TS_W-1:0] sec;
    logic [TS_W-1:0] nsec;
    logic [TS_W-1:0] stat;
  } ts_entry_t;

  function automatic logic [PID_W-1:0] pid_of(input logic [TS_W-1:0] nsec);
    return nsec[PID_W-1:0];
  endfunction

  function automatic logic pid_is_bad(input logic [PID_W-1:0] pid);
    return pid == PID_BAD;
  endfunction

  // successor modulo PID_BAD: the highest valid ID wraps to zero
  function automatic logic [PID_W-1:0] pid_succ(input logic [PID_W-1:0] pid);
    return (pid == PID_LAST) ? '0 : pid + 1'b1;
  endfunction
endpackage

// File: rtl/fts_capture.sv
module fts_capture
  import fts_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fid_i,
  input  logic            new_valid_i,
  input  ts_entry_t       new_entry_i,
  input  logic [TS_W-1:0] sys_sec_i,
  input  logic [TS_W-1:0] sys_nsec_i,
  output ts_entry_t       cand_o,
  output logic            fresh_o
);
  ts_entry_t held_q;
  logic      held_v_q;
  ts_entry_t fill;

  always_comb begin
    fill.sec  = sys_sec_i;
    fill.nsec = sys_nsec_i | TS_W'(PID_BAD);
    fill.stat = '1;
  end

  always_comb begin
    if (new_valid_i)   cand_o = new_entry_i;
    else if (held_v_q) cand_o = held_q;
    else               cand_o = fill;
    fresh_o = new_valid_i | held_v_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q   <= '0;
      held_v_q <= 1'b0;
    end else if (fid_i) begin
      held_v_q <= 1'b0;
    end else if (new_valid_i) begin
      held_q   <= new_entry_i;
      held_v_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fts_check.sv
module fts_check
  import fts_pkg::*;
(
  input  logic [PID_W-1:0] cand_pid_i,
  input  logic [PID_W-1:0] tail_pid_i,
  input  logic [PID_W-1:0] pre_pid_i,
  output logic             bad_o,
  output logic             gap_o,
  output logic             rep_o
);
  always_comb begin
    bad_o = pid_is_bad(cand_pid_i);
    gap_o = !bad_o && !pid_is_bad(tail_pid_i) && (cand_pid_i != pid_succ(tail_pid_i));
    rep_o = (cand_pid_i == tail_pid_i) && (cand_pid_i == pre_pid_i);
  end
endmodule

// File: rtl/fts_sat_cnt.sv
module fts_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (inc_i && ~&cnt_o)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fid_ts_pipeline.sv
module fid_ts_pipeline
  import fts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fid_i,
  input  logic                        new_valid_i,
  input  logic [31:0]                 new_sec_i,
  input  logic [31:0]                 new_nsec_i,
  input  logic [31:0]                 new_stat_i,
  input  logic [31:0]                 sys_sec_i,
  input  logic [31:0]                 sys_nsec_i,
  input  logic                        cnt_clr_i,
  output logic [DEPTH-1:0][31:0]      slot_sec_o,
  output logic [DEPTH-1:0][31:0]      slot_nsec_o,
  output logic [DEPTH-1:0][31:0]      slot_stat_o,
  output logic                        err_o,
  output logic [CNT_W-1:0]            bad_id_cnt_o,
  output logic [CNT_W-1:0]            gap_cnt_o
);
  localparam int unsigned TAIL = DEPTH - 1;
  localparam int unsigned PRE  = DEPTH - 2;

  ts_entry_t slot_q [DEPTH];
  ts_entry_t new_entry;
  ts_entry_t cand;
  ts_entry_t sys_entry;
  logic      cand_fresh;

  // named events for the checker
  logic advance;
  logic ev_bad;
  logic ev_gap;
  logic ev_rep;

  assign advance = fid_i;

  always_comb begin
    new_entry.sec  = new_sec_i;
    new_entry.nsec = new_nsec_i;
    new_entry.stat = new_stat_i;
    sys_entry.sec  = sys_sec_i;
    sys_entry.nsec = sys_nsec_i;
    sys_entry.stat = '1;
  end

  fts_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .fid_i       (fid_i),
    .new_valid_i (new_valid_i),
    .new_entry_i (new_entry),
    .sys_sec_i   (sys_sec_i),
    .sys_nsec_i  (sys_nsec_i),
    .cand_o      (cand),
    .fresh_o     (cand_fresh)
  );

  fts_check u_chk_pid (
    .cand_pid_i (pid_of(cand.nsec)),
    .tail_pid_i (pid_of(slot_q[TAIL].nsec)),
    .pre_pid_i  (pid_of(slot_q[PRE].nsec)),
    .bad_o      (ev_bad),
    .gap_o      (ev_gap),
    .rep_o      (ev_rep)
  );

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i < TAIL) begin : g_mid
        always_ff @(posedge clk) begin
          if (!rst_n)       slot_q[i] <= sys_entry;
          else if (advance) slot_q[i] <= slot_q[i+1];
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            slot_q[i] <= sys_entry;
          end else if (advance) begin
            slot_q[i].sec  <= cand.sec;
            slot_q[i].nsec <= cand.nsec;
            slot_q[i].stat <= ev_rep ? '1 : cand.stat;
          end
        end
      end
      assign slot_sec_o[i]  = slot_q[i].sec;
      assign slot_nsec_o[i] = slot_q[i].nsec;
      assign slot_stat_o[i] = slot_q[i].stat;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       err_o <= 1'b0;
    else if (advance) err_o <= ev_bad | ev_gap;
  end

  fts_sat_cnt #(.W(CNT_W)) u_cnt_bad (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr_i),
    .inc_i (advance & ev_bad),
    .cnt_o (bad_id_cnt_o)
  );

  fts_sat_cnt #(.W(CNT_W)) u_cnt_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr_i),
    .inc_i (advance & ev_gap),
    .cnt_o (gap_cnt_o)
  );
endmodule

// File: rtl/fts_chk.sv
module fts_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fid_i,
  input logic                   cnt_clr_i,
  input logic [DEPTH-1:0][31:0] slot_sec_o,
  input logic [DEPTH-1:0][31:0] slot_nsec_o,
  input logic [DEPTH-1:0][31:0] slot_stat_o,
  input logic                   err_o,
  input logic [CNT_W-1:0]       bad_id_cnt_o,
  input logic [CNT_W-1:0]       gap_cnt_o,
  input logic                   cand_fresh,
  input logic                   ev_bad,
  input logic                   ev_gap,
  input logic                   ev_rep
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fid_i |=> (slot_sec_o[0] == $past(slot_sec_o[1])) && (slot_nsec_o[0] == $past(slot_nsec_o[1]))
              && (slot_stat_o[0] == $past(slot_stat_o[1])));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fid_i |=> $stable(slot_sec_o) && $stable(slot_nsec_o) && $stable(slot_stat_o));

  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_i && !cand_fresh) |=> (slot_stat_o[DEPTH-1] == 32'hFFFF_FFFF)
                               && (slot_nsec_o[DEPTH-1][16:0] == 17'h1FFFF));

  p_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_i && ev_rep) |=> slot_stat_o[DEPTH-1] == 32'hFFFF_FFFF);

  p_bad_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_i && ev_bad && !cnt_clr_i && (bad_id_cnt_o != {CNT_W{1'b1}}))
      |=> bad_id_cnt_o == CNT_W'($past(bad_id_cnt_o) + 1'b1));

  p_gap_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_i && ev_gap && !cnt_clr_i && (gap_cnt_o != {CNT_W{1'b1}}))
      |=> gap_cnt_o == CNT_W'($past(gap_cnt_o) + 1'b1));

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fid_i |=> err_o == $past(ev_bad || ev_gap));

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fid_i |=> $stable(err_o));

  p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr_i && (bad_id_cnt_o == {CNT_W{1'b1}})) |=> bad_id_cnt_o == {CNT_W{1'b1}});

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (bad_id_cnt_o == '0) && (gap_cnt_o == '0));
endmodule

bind fid_ts_pipeline fts_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fts_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fid_i        (fid_i),
  .cnt_clr_i    (cnt_clr_i),
  .slot_sec_o   (slot_sec_o),
  .slot_nsec_o  (slot_nsec_o),
  .slot_stat_o  (slot_stat_o),
  .err_o        (err_o),
  .bad_id_cnt_o (bad_id_cnt_o),
  .gap_cnt_o    (gap_cnt_o),
  .cand_fresh   (cand_fresh),
  .ev_bad       (ev_bad),
  .ev_gap       (ev_gap),
  .ev_rep       (ev_rep)
);

// File: tb/tb_fid_ts_pipeline.sv
`timescale 1ns/1ps
module tb_fid_ts_pipeline;
  localparam int D  = 4;
  localparam int CW = 3;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fid_i = 1'b0, new_valid_i = 1'b0, cnt_clr_i = 1'b0;
  logic [31:0] new_sec_i = '0, new_nsec_i = '0, new_stat_i = '0;
  logic [31:0] sys_sec_i = '0, sys_nsec_i = '0;
  logic [D-1:0][31:0] slot_sec_o, slot_nsec_o, slot_stat_o;
  logic err_o;
  logic [CW-1:0] bad_id_cnt_o, gap_cnt_o;

  always #2 clk = ~clk;

  fid_ts_pipeline #(.DEPTH(D), .CNT_W(CW)) dut (.*);

  int nchk = 0, nerr = 0;
  bit finished = 0;

  logic [31:0] m_sec [D], m_nsec [D], m_stat [D];
  logic m_err;
  logic [CW-1:0] m_bad, m_gap;
  bit h_v;
  logic [31:0] h_sec, h_nsec, h_stat;

  function automatic logic [16:0] bnext(input logic [16:0] p);
    int unsigned v;
    v = (int'(p) + 1) % 32'h1FFFF;
    return v[16:0];
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < D; i++) begin
      cmp(tag, $sformatf("sec[%0d]", i), slot_sec_o[i], m_sec[i]);
      cmp(tag, $sformatf("nsec[%0d]", i), slot_nsec_o[i], m_nsec[i]);
      cmp(tag, $sformatf("stat[%0d]", i), slot_stat_o[i], m_stat[i]);
    end
    cmp(tag, "err", 32'(err_o), 32'(m_err));
    cmp(tag, "bad_cnt", 32'(bad_id_cnt_o), 32'(m_bad));
    cmp(tag, "gap_cnt", 32'(gap_cnt_o), 32'(m_gap));
  endtask

  task automatic tick(input bit f, input bit nv, input logic [31:0] s, input logic [31:0] ns,
                      input logic [31:0] st, input bit c, input string tag);
    logic [31:0] cs, cn, ct;
    logic [16:0] p, pt, pp;
    bit bad, gap, rep;
    fid_i = f; new_valid_i = nv; new_sec_i = s; new_nsec_i = ns; new_stat_i = st; cnt_clr_i = c;
    sys_sec_i = $urandom; sys_nsec_i = $urandom;
    if (nv)       begin cs = s; cn = ns; ct = st; end
    else if (h_v) begin cs = h_sec; cn = h_nsec; ct = h_stat; end
    else          begin cs = sys_sec_i; cn = {sys_nsec_i[31:17], 17'h1FFFF}; ct = 32'hFFFF_FFFF; end
    p = cn[16:0]; pt = m_nsec[D-1][16:0]; pp = m_nsec[D-2][16:0];
    bad = (p == 17'h1FFFF);
    gap = !bad && (pt != 17'h1FFFF) && (p != bnext(pt));
    rep = (p == pt) && (p == pp);
    @(posedge clk);
    if (f) begin
      for (int i = 0; i < D-1; i++) begin
        m_sec[i] = m_sec[i+1]; m_nsec[i] = m_nsec[i+1]; m_stat[i] = m_stat[i+1];
      end
      m_sec[D-1] = cs; m_nsec[D-1] = cn; m_stat[D-1] = rep ? 32'hFFFF_FFFF : ct;
      m_err = bad | gap;
      h_v = 0;
    end else if (nv) begin
      h_v = 1; h_sec = s; h_nsec = ns; h_stat = st;
    end
    if (c) begin m_bad = '0; m_gap = '0; end
    else begin
      if (f && bad && m_bad != CMAX) m_bad = m_bad + 1'b1;
      if (f && gap && m_gap != CMAX) m_gap = m_gap + 1'b1;
    end
    @(negedge clk);
    compare_all(tag);
    fid_i = 0; new_valid_i = 0; cnt_clr_i = 0;
  endtask

  function automatic logic [31:0] mk(input logic [16:0] pid);
    logic [31:0] r;
    r = $urandom;
    return {r[14:0], pid};
  endfunction

  // load an entry with the given pulse ID at a strobe
  task automatic push(input logic [16:0] pid, input string tag);
    tick(1, 1, $urandom, mk(pid), 32'h0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd24681));
    sys_sec_i = 32'h1234_5678; sys_nsec_i = 32'h0ABC_D123;
    rst_n = 0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < D; i++) begin
      m_sec[i] = 32'h1234_5678; m_nsec[i] = 32'h0ABC_D123; m_stat[i] = 32'hFFFF_FFFF;
    end
    m_err = 0; m_bad = '0; m_gap = '0; h_v = 0;
    @(negedge clk);
    compare_all("R1 reset state");
    rst_n = 1;
    tick(0, 0, 0, 0, 0, 0, "R1 after release");
    tick(0, 0, 0, 0, 0, 0, "R2 idle no change");

    // R3 basic loads, consecutive IDs
    push(17'd100, "R3 first load");
    push(17'd101, "R3 consecutive");
    push(17'd102, "R2 R3 shift");
    push(17'd103, "R2 R3 shift full");
    // R4 missing entry
    tick(1, 0, 0, 0, 0, 0, "R4 missing fill R5");
    // R3 held entry offered before strobe; latest of two wins
    tick(0, 1, 32'hAAAA_0001, mk(17'd7), 32'h0, 0, "R3 offer early");
    tick(0, 1, 32'hAAAA_0002, mk(17'd8), 32'h0, 0, "R3 offer later");
    tick(0, 0, 0, 0, 0, 0, "R2 idle with held");
    tick(1, 0, 0, 0, 0, 0, "R3 held used at strobe");
    // R3 same-cycle offer beats held entry
    tick(0, 1, 32'hBBBB_0001, mk(17'd40), 32'h0, 0, "R3 held");
    tick(1, 1, 32'hBBBB_0002, mk(17'd9), 32'h0, 0, "R3 same cycle wins");
    tick(1, 0, 0, 0, 0, 0, "R4 held cleared after strobe");
    // R6 wrap
    push(17'h1FFFD, "R6 pre wrap");
    push(17'h1FFFE, "R6 last valid");
    push(17'h00000, "R6 wrap to zero no gap");
    push(17'h00002, "R6 gap detected R8");
    tick(0, 0, 0, 0, 0, 0, "R8 err held between strobes");
    push(17'h00003, "R8 err clears");
    // R7 repeat
    push(17'd50, "R7 setup");
    push(17'd50, "R7 second same");
    push(17'd50, "R7 third same invalidated");
    push(17'd51, "R7 resume");
    // R5 invalid pulse ID offered explicitly
    tick(1, 1, $urandom, mk(17'h1FFFF), 32'h0, 0, "R5 invalid id");
    // R9 saturation
    for (int k = 0; k < 10; k++) tick(1, 0, 0, 0, 0, 0, "R9 saturate bad count");
    for (int k = 0; k < 10; k++) push(17'(k * 3), "R9 saturate gap count");
    // R10 clear against increment
    tick(1, 0, 0, 0, 0, 1, "R10 clear beats increment");
    tick(1, 0, 0, 0, 0, 0, "R10 count resumes");

    // constrained random
    begin
      logic [16:0] np;
      np = 17'd1000;
      for (int n = 0; n < 1500; n++) begin
        int r, idle;
        bit early;
        logic [16:0] use_pid;
        r = $urandom % 16;
        idle = $urandom % 4;
        early = ($urandom % 2) == 1;
        np = bnext(np);
        case (r)
          0: use_pid = 17'h1FFFF;
          1: use_pid = np + 17'd5;
          2: use_pid = m_nsec[D-1][16:0];
          default: use_pid = np;
        endcase
        if (use_pid == 17'h1FFFF && r != 0) use_pid = 17'd0;
        for (int k = 0; k < idle; k++)
          tick(0, early && k == 0, $urandom, mk(use_pid), 32'h0, ($urandom % 40) == 0, "R2 random idle");
        if (r == 3 && idle > 0 && early)
          tick(1, 0, 0, 0, 0, 0, "R3 random held");
        else if (r == 4 && !(idle > 0 && early))
          tick(1, 0, 0, 0, 0, ($urandom % 40) == 0, "R4 random missing");
        else
          tick(1, 1, $urandom, mk(use_pid), ($urandom % 8 == 0) ? 32'hFFFF_FFFF : 32'h0,
               ($urandom % 40) == 0, "R5 R6 R7 R9 R10 random strobe");
        if (r == 1) np = use_pid;
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule